// File: doc/BRIEF.md
# Tiled 53x53 significand multiplier

This block multiplies two 53-bit unsigned significands (hidden bit included) and returns the exact 106-bit product. It is the mantissa core of a double-precision multiply path. Instead of one wide inferred multiply, it is built from nine small unsigned multiplier tiles, each 24 bits by 17 bits, plus a thin AND-gated strip. Together these cover the whole 53x53 partial-product area. Each tile is a plain registered multiply, so no hard macro is required. A registered pairwise adder tree sums the shift-aligned partial products.

The low 48 bits of operand A are cut into two 24-bit rows. Each row meets three 17-bit columns of operand B, which gives six tiles. The top 5 bits of A meet B in three further tiles, where B sits on the wide side of each tile in 24-bit pieces. The two top bits of B, facing the low 48 bits of A, are too narrow for a tile, so the strip adds them as two gated copies of A.

Data moves on a valid/ready stream at both ends. An operand pair transfers in a cycle where `in_valid` and `in_ready` are both high. A product transfers in a cycle where `out_valid` and `out_ready` are both high. The pipeline advances as a whole whenever its output register is empty or is being read. `in_ready` therefore follows `out_ready` combinationally. While a product waits unread, every stage holds and no new operands are taken. The latency is fixed at six cycles and the throughput is one product per cycle.

Top module: `mul53_tiled`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the exact 106-bit unsigned product of the operand pair, with no bit dropped or rounded.
- R2: With `out_ready` held high, a pair accepted in cycle c produces `out_valid` high, carrying its product, in cycle c+6.
- R3: With `out_ready` held high, `in_ready` stays high. Pairs offered in consecutive cycles are all accepted and come out in consecutive cycles, in order.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prod` keeps its value into the next cycle.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R6: While `rst` is high and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R7: All-ones operands (2^53-1 on both inputs) give 2^106 - 2^54 + 1, so the carries through the top of the adder tree are exact.
- R8: For operands that are each a single set bit, at positions i and j chosen from 0, 16, 17, 23, 24, 33, 34, 47, 48, 50, 51 and 52, the product is 2^(i+j). These positions sit at every slice boundary of both operands.
- R9: A cycle with `in_valid` low creates no output item. The number of products delivered equals the number of pairs accepted, and they arrive in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the operand pair this cycle |
| in_a | input | 53 | Operand A significand |
| in_b | input | 53 | Operand B significand |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_valid | output | 1 | Product present |
| out_prod | output | 106 | Exact product of A and B |

## Verification
The bench walks single set bits across every slice boundary of both operands. A shift offset or slice width that is off by one would then move or lose the product bit, and a missing column, for example the two-bit strip on top of B, would return zero for that pair. All-ones operands drive carries across every tree level; an adder that is one bit too narrow would drop the top carry and corrupt the high bits. Random out_ready patterns and long stalls probe back-pressure. A stage that ignored the stall would change a waiting product, or duplicate or lose an item, which the scoreboard sees as a mismatch or a count error. A bubble-laden input stream checks that idle cycles never produce an output.

// File: rtl/mul53_pkg.sv
package mul53_pkg;

  localparam int SIG_W       = 53;
  localparam int TILE_WIDE   = 24;
  localparam int TILE_NARROW = 17;

  // number of live entries left after l pairwise reduction levels of n terms
  function automatic int lvl_count(input int n, input int l);
    int m;
    m = n;
    for (int i = 0; i < l; i++) m = (m + 1) / 2;
    return m;
  endfunction

endpackage

// File: rtl/mul_tile.sv
module mul_tile #(
  parameter int WA = 24,
  parameter int WB = 17
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WA-1:0]    a,
  input  logic [WB-1:0]    b,
  output logic [WA+WB-1:0] p
);

  localparam int PWD = WA + WB;

  logic [WA-1:0]  a_q;
  logic [WB-1:0]  b_q;
  logic [PWD-1:0] p_q;

  always_ff @(posedge clk) begin
    if (en) begin
      a_q <= a;
      b_q <= b;
      p_q <= PWD'(a_q) * PWD'(b_q);
    end
  end

  assign p = p_q;

endmodule

// File: rtl/strip_mul.sv
module strip_mul #(
  parameter int WA = 48,
  parameter int WB = 2
) (
  input  logic             clk,
  input  logic             en,
  input  logic [WA-1:0]    a,
  input  logic [WB-1:0]    b,
  output logic [WA+WB-1:0] p
);

  localparam int PWD = WA + WB;

  logic [WA-1:0]  a_q;
  logic [WB-1:0]  b_q;
  logic [PWD-1:0] acc;
  logic [PWD-1:0] p_q;

  // gated shifted copies of A, one per narrow bit
  always_comb begin
    acc = '0;
    for (int j = 0; j < WB; j++) begin
      if (b_q[j]) acc = acc + (PWD'(a_q) << j);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      a_q <= a;
      b_q <= b;
      p_q <= acc;
    end
  end

  assign p = p_q;

endmodule

// File: rtl/sum_tree.sv
module sum_tree import mul53_pkg::*; #(
  parameter int NT  = 10,
  parameter int PW  = 106,
  parameter int LVL = 4
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic [NT-1:0][PW-1:0]  terms,
  output logic [PW-1:0]          sum
);

  for (genvar l = 1; l <= LVL; l++) begin : g_lvl
    localparam int PREV = lvl_count(NT, l - 1);
    localparam int NOW  = lvl_count(NT, l);

    logic [2*NT-1:0][PW-1:0] prv;
    logic [NT-1:0][PW-1:0]   q;

    if (l == 1) begin : g_src_in
      assign prv = {{(NT*PW){1'b0}}, terms};
    end else begin : g_src_lvl
      assign prv = {{(NT*PW){1'b0}}, g_lvl[l-1].q};
    end

    always_ff @(posedge clk) begin
      if (en) begin
        for (int i = 0; i < NT; i++) begin
          if (i < NOW) begin
            if (2 * i + 1 < PREV) q[i] <= prv[2*i] + prv[2*i+1];
            else                  q[i] <= prv[2*i];
          end else begin
            q[i] <= '0;
          end
        end
      end
    end
  end

  assign sum = g_lvl[LVL].q[0];

endmodule

// File: rtl/mul53_tiled.sv
module mul53_tiled import mul53_pkg::*; #(
  parameter int OPW = SIG_W,
  parameter int TWA = TILE_WIDE,
  parameter int TWB = TILE_NARROW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPW-1:0]    in_a,
  input  logic [OPW-1:0]    in_b,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [2*OPW-1:0]  out_prod
);

  localparam int PW    = 2 * OPW;
  localparam int XR    = OPW / TWA;             // wide rows of A
  localparam int XC    = OPW / TWB;             // narrow columns of B
  localparam int SW    = XR * TWA;              // A bits covered by rows
  localparam int A_TOP = OPW - SW;              // leftover top of A
  localparam int B_TOP = OPW - XC * TWB;        // leftover top of B
  localparam int YN    = (OPW + TWA - 1) / TWA; // tiles for the A top row
  localparam int NT    = XR * XC + YN + 1;      // partial products
  localparam int LVL   = $clog2(NT);
  localparam int LAT   = 2 + LVL;
  localparam int XP    = TWA + TWB;
  localparam int BXW   = YN * TWA;

  logic                  adv;
  logic [LAT-1:0]        vpipe;
  logic [NT-1:0][PW-1:0] terms;
  logic [BXW-1:0]        b_ext;
  logic [TWB-1:0]        a_hi;
  logic [SW+B_TOP-1:0]   strip_p;

  // whole pipeline moves when the output slot is free or being drained
  assign adv      = !vpipe[LAT-1] || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst)      vpipe <= '0;
    else if (adv) vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

  assign b_ext = {{(BXW - OPW){1'b0}}, in_b};
  assign a_hi  = {{(TWB - A_TOP){1'b0}}, in_a[OPW-1 -: A_TOP]};

  // low rows of A against narrow columns of B
  for (genvar r = 0; r < XR; r++) begin : g_row
    for (genvar c = 0; c < XC; c++) begin : g_col
      logic [XP-1:0] p;
      mul_tile #(.WA(TWA), .WB(TWB)) u_tile (
        .clk (clk),
        .en  (adv),
        .a   (in_a[r*TWA +: TWA]),
        .b   (in_b[c*TWB +: TWB]),
        .p   (p)
      );
      assign terms[r*XC + c] = PW'(p) << (r * TWA + c * TWB);
    end
  end

  // top of A on the narrow side, B in wide pieces on the other
  for (genvar k = 0; k < YN; k++) begin : g_top
    logic [XP-1:0] p;
    mul_tile #(.WA(TWA), .WB(TWB)) u_tile (
      .clk (clk),
      .en  (adv),
      .a   (b_ext[k*TWA +: TWA]),
      .b   (a_hi),
      .p   (p)
    );
    assign terms[XR*XC + k] = PW'(p) << (SW + k * TWA);
  end

  // top bits of B against the low rows of A
  strip_mul #(.WA(SW), .WB(B_TOP)) u_strip (
    .clk (clk),
    .en  (adv),
    .a   (in_a[SW-1:0]),
    .b   (in_b[OPW-1 -: B_TOP]),
    .p   (strip_p)
  );
  assign terms[NT-1] = PW'(strip_p) << (XC * TWB);

  sum_tree #(.NT(NT), .PW(PW), .LVL(LVL)) u_tree (
    .clk   (clk),
    .en    (adv),
    .terms (terms),
    .sum   (out_prod)
  );

endmodule

// File: rtl/mul53_chk.sv
module mul53_chk #(
  parameter int OPW = 53,
  parameter int LAT = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OPW-1:0]   in_a,
  input logic [OPW-1:0]   in_b,
  input logic             out_ready,
  input logic             out_valid,
  input logic [2*OPW-1:0] out_prod
);

  localparam int PW = 2 * OPW;

  logic [LAT-1:0] v_m;
  logic [PW-1:0]  e_m [LAT];
  logic           mv;

  assign mv = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)     v_m <= '0;
    else if (mv) v_m <= {v_m[LAT-2:0], in_valid && in_ready};
  end

  always_ff @(posedge clk) begin
    if (mv) begin
      e_m[0] <= PW'(in_a) * PW'(in_b);
      for (int i = 1; i < LAT; i++) e_m[i] <= e_m[i-1];
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_m[LAT-1]);

  p_exact_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod == e_m[LAT-1]);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_prod));

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_open_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_reset_r6: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind mul53_tiled mul53_chk #(.OPW(OPW), .LAT(LAT)) u_chk (.*);

// File: tb/mul53_tiled_tb_top.sv
`timescale 1ns/1ps
module mul53_tiled_tb_top;

  localparam int OPW = 53;
  localparam int PW  = 2 * OPW;
  localparam int LAT = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [OPW-1:0]  in_a = '0;
  logic [OPW-1:0]  in_b = '0;
  logic            out_ready = 1'b1;
  logic            out_valid;
  logic [PW-1:0]   out_prod;

  typedef struct {
    logic [PW-1:0] exp;
    string         tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  int    sent   = 0;
  int    got    = 0;
  int    rmode  = 0;
  bit    done   = 1'b0;

  always #2 clk = ~clk;

  mul53_tiled dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_prod  (out_prod)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // consumer side: ready pattern per mode
  always @(negedge clk) begin
    case (rmode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'($urandom_range(0, 1));
      default: out_ready = ($urandom_range(0, 7) == 0);
    endcase
  end

  task automatic send(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                      input string tag);
    bit    acc;
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    acc      = 1'b0;
    while (!acc) begin
      #1;
      acc = in_ready;
      if (rmode == 0) check(acc, "R3 in_ready with out_ready high", PW'(acc), PW'(1));
      @(posedge clk);
      if (acc) begin
        it.exp = PW'(a) * PW'(b);
        it.tag = tag;
        sb.push_back(it);
        sent++;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [OPW-1:0] rnd();
    return OPW'({$urandom, $urandom});
  endfunction

  // monitor / scoreboard
  initial begin
    bit            held;
    logic [PW-1:0] held_val;
    item_t         it;
    held = 1'b0;
    held_val = '0;
    wait (!rst);
    forever begin
      @(negedge clk);
      #1;
      check(in_ready == (!out_valid || out_ready), "R5 in_ready rule",
            PW'(in_ready), PW'(!out_valid || out_ready));
      if (held) begin
        check(out_valid == 1'b1, "R4 valid held", PW'(out_valid), PW'(1));
        check(out_prod == held_val, "R4 product held", out_prod, held_val);
      end
      held     = out_valid && !out_ready;
      held_val = out_prod;
      if (out_valid && out_ready) begin
        got++;
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected output", out_prod, '0);
        end else begin
          it = sb.pop_front();
          check(out_prod == it.exp, {"R1 product ", it.tag}, out_prod, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d outputs", got, sent);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam int NB = 12;
  int bpos [NB] = '{0, 16, 17, 23, 24, 33, 34, 47, 48, 50, 51, 52};

  initial begin
    int            cnt;
    logic [OPW-1:0] ones;
    ones = '1;

    // R6: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R6 out_valid in reset", PW'(out_valid), PW'(0));
    check(in_ready == 1'b1, "R6 in_ready in reset", PW'(in_ready), PW'(1));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R6 out_valid after reset", PW'(out_valid), PW'(0));
    check(in_ready == 1'b1, "R6 in_ready after reset", PW'(in_ready), PW'(1));

    // R2: latency of a lone item
    rmode = 0;
    send(53'd12345, 53'd678, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    cnt = 1;
    while (!out_valid && cnt < 20) begin
      @(negedge clk); #1;
      cnt++;
    end
    check(cnt == LAT, "R2 latency", PW'(cnt), PW'(LAT));
    idle(4);

    // R7: all-ones and simple corners
    send(ones, ones, "R7 all ones");
    check((PW'(ones) * PW'(ones)) == ((PW'(1) << 106) - (PW'(1) << 54) + PW'(1)),
          "R7 bench reference", PW'(ones) * PW'(ones), (PW'(1) << 106) - (PW'(1) << 54) + PW'(1));
    send(ones, 53'd1, "R7 ones by one");
    send(53'd0, ones, "R7 zero");
    send(ones, 53'h10_0000_0000_0000, "R7 ones by top bit");

    // R8 and R3: walking single bits across slice boundaries, back to back
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        send(OPW'(1) << bpos[i], OPW'(1) << bpos[j], "R8 boundary bits");
    idle(10);

    // R1 and R4: random operands with random and sparse ready
    rmode = 1;
    for (int n = 0; n < 200; n++) send(rnd(), rnd(), "R1 random");
    rmode = 2;
    for (int n = 0; n < 80; n++) send(rnd(), ones, "R4 sparse ready");

    // R9: bubbles between inputs
    rmode = 1;
    for (int n = 0; n < 40; n++) begin
      send(rnd(), rnd(), "R9 bubbles");
      idle($urandom_range(0, 3));
    end
    idle(1);

    // drain
    rmode = 0;
    cnt = 0;
    while (sb.size() != 0 && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    repeat (LAT + 2) @(negedge clk);
    check(sb.size() == 0, "R9 queue drained", PW'(sb.size()), PW'(0));
    check(got == sent, "R9 output count", PW'(got), PW'(sent));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule